// File: doc/BRIEF.md
# Intra 16x16 Directional and DC Luma Predictor

This block builds a 16x16 block of 8-bit predicted luma samples from the reconstructed neighbours of a macroblock. The caller presents the sixteen samples above the block, the sixteen samples to its left, two flags that say which of those edges exist, and a 2-bit mode. A one-cycle start pulse loads all of them into the block. The predictor then streams one 128-bit row per clock, starting at the top row, and flags the last row.

Three prediction rules are computed here: copy the row above downwards, copy each left sample across its row, or fill the block with a single averaged value. When the averaged (DC) rule is chosen, the average is taken over whichever edges exist. Plane prediction is recognised but not computed here. For that mode the block raises a single-cycle hand-off pulse so that a separate plane generator can take over, and it emits no rows itself.

Top module: `intra16_pred`

## Requirements
- R1: When `start` is high and no block is being output (`row_valid` low), the mode and neighbour inputs are captured. For modes 0, 1 and 2, rows appear from the next cycle on, one per cycle, with `row_valid` high and `row_idx` counting 0 to 15.
- R2: In mode 0 (vertical), every output row equals the captured above vector. Sample x is held in bits [8x+7:8x] of `above`, `left` and `row_data`.
- R3: In mode 1 (horizontal), row y carries left sample y (bits [8y+7:8y] of `left`) in all 16 columns.
- R4: In mode 2 (DC) with both edge flags low, every sample is 128.
- R5: In mode 2 with only `avail_up` high, every sample is (sum of the 16 above samples + 8) >> 4.
- R6: In mode 2 with only `avail_left` high, every sample is (sum of the 16 left samples + 8) >> 4.
- R7: In mode 2 with both flags high, every sample is (sum of all 32 samples + 16) >> 5. The result reaches 255 without wrapping when all inputs are 255.
- R8: `done` is high for exactly one cycle, together with row 15, and `row_valid` is low in the cycle after it.
- R9: A `start` pulse that arrives while `row_valid` is high has no effect on the rows being output.
- R10: Mode 3 (plane) raises `plane_go` for one cycle, in the cycle after `start`, and produces no rows.
- R11: Changing `above`, `left`, `mode` or the flags after capture does not alter the rows being output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin a block |
| mode | input | 2 | 0 vertical, 1 horizontal, 2 DC, 3 plane |
| avail_up | input | 1 | Above edge present |
| avail_left | input | 1 | Left edge present |
| above | input | 128 | Sixteen samples above the block, sample x at [8x+7:8x] |
| left | input | 128 | Sixteen samples left of the block, sample y at [8y+7:8y] |
| row_data | output | 128 | Predicted row, column x at [8x+7:8x] |
| row_valid | output | 1 | `row_data` holds a row |
| row_idx | output | 4 | Index of the current row |
| done | output | 1 | Pulses with the last row |
| plane_go | output | 1 | One-cycle hand-off for plane mode |

## Verification
The assertions assume that `start` is only meaningful while the block is idle. They also assume the caller never expects a second block to begin in the same cycle as `done`, because the row sequencer treats a start in that cycle as arriving during output.

The stimulus keeps to this in two ways. It issues each new block only after observing `row_valid` low. Its deliberate mid-block start pulses fall strictly inside the sixteen-row window, so every ignored start is one the assertions also regard as ignored.

// File: rtl/intra16_pred.sv
module intra16_pred #(
  parameter int PW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic                avail_up,
  input  logic                avail_left,
  input  logic [16*PW-1:0]    above,
  input  logic [16*PW-1:0]    left,
  output logic [16*PW-1:0]    row_data,
  output logic                row_valid,
  output logic [3:0]          row_idx,
  output logic                done,
  output logic                plane_go
);
  localparam int N  = 16;
  localparam int RW = N * PW;
  localparam int EW = PW + 4;
  localparam int BW = PW + 5;

  logic          busy, plane_q, up_q, lf_q;
  logic [3:0]    cnt;
  logic [1:0]    mode_q;
  logic [RW-1:0] above_q, left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      plane_q <= 1'b0;
      cnt     <= '0;
      mode_q  <= '0;
      up_q    <= 1'b0;
      lf_q    <= 1'b0;
      above_q <= '0;
      left_q  <= '0;
    end else begin
      plane_q <= 1'b0;
      if (busy) begin
        cnt <= cnt + 4'd1;
        if (cnt == 4'(N - 1)) busy <= 1'b0;
      end else if (start) begin
        mode_q  <= mode;
        up_q    <= avail_up;
        lf_q    <= avail_left;
        above_q <= above;
        left_q  <= left;
        cnt     <= '0;
        if (mode == 2'd3) plane_q <= 1'b1;
        else              busy    <= 1'b1;
      end
    end
  end

  logic [EW-1:0] sum_up, sum_lf, one_edge;
  logic [BW-1:0] two_edge;
  logic [PW-1:0] dc_val, hor_val;

  always_comb begin
    sum_up = '0;
    sum_lf = '0;
    for (int i = 0; i < N; i++) begin
      sum_up = sum_up + EW'(above_q[i*PW +: PW]);
      sum_lf = sum_lf + EW'(left_q[i*PW +: PW]);
    end
    one_edge = (up_q ? sum_up : sum_lf) + EW'(8);
    two_edge = BW'(sum_up) + BW'(sum_lf) + BW'(16);
    case ({up_q, lf_q})
      2'b00:   dc_val = PW'(1) << (PW - 1);
      2'b11:   dc_val = two_edge[BW-1:5];
      default: dc_val = one_edge[EW-1:4];
    endcase
  end

  assign hor_val = left_q[cnt*PW +: PW];

  always_comb begin
    case (mode_q)
      2'd0:    row_data = above_q;
      2'd1:    row_data = {N{hor_val}};
      2'd2:    row_data = {N{dc_val}};
      default: row_data = '0;
    endcase
  end

  assign row_valid = busy;
  assign row_idx   = cnt;
  assign done      = busy && (cnt == 4'(N - 1));
  assign plane_go  = plane_q;
endmodule

// File: rtl/intra16_pred_chk.sv
module intra16_pred_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] mode,
  input logic       row_valid,
  input logic [3:0] row_idx,
  input logic       done,
  input logic       plane_go
);
  a_r1_first_row: assert property (@(posedge clk) disable iff (!rst_n)
    start && !row_valid && mode != 2'd3 |=> row_valid && row_idx == 4'd0);

  a_r9_rows_advance: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && !done |=> row_valid && row_idx == $past(row_idx) + 4'd1);

  a_r8_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> row_valid && row_idx == 4'd15);

  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !row_valid && !done);

  a_r10_plane_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start && !row_valid && mode == 2'd3 |=> plane_go && !row_valid);

  a_r10_plane_no_rows: assert property (@(posedge clk) disable iff (!rst_n)
    plane_go |-> !row_valid);
endmodule

bind intra16_pred intra16_pred_chk u_chk (.*);

// File: tb/tb_intra16_pred.sv
module tb_intra16_pred;
  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]   mode = '0;
  logic         avail_up = 1'b0, avail_left = 1'b0;
  logic [127:0] above = '0, left = '0;
  logic [127:0] row_data;
  logic         row_valid, done, plane_go;
  logic [3:0]   row_idx;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  intra16_pred dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dc_of(input logic [127:0] a, input logic [127:0] l,
                                       input logic u, input logic lf);
    int su = 0, sl = 0;
    for (int i = 0; i < 16; i++) begin
      su += a[i*8 +: 8];
      sl += l[i*8 +: 8];
    end
    if (u && lf) return 8'((su + sl + 16) / 32);
    if (u)       return 8'((su + 8) / 16);
    if (lf)      return 8'((sl + 8) / 16);
    return 8'd128;
  endfunction

  task automatic run_block(input logic [1:0] m, input logic u, input logic lf,
                           input logic [127:0] a, input logic [127:0] l, input bit disturb);
    logic [127:0] exp;
    string req;
    @(negedge clk);
    mode = m; avail_up = u; avail_left = lf; above = a; left = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req = (m == 0) ? "R2" : (m == 1) ? "R3" : (!u && !lf) ? "R4" :
          (u && !lf) ? "R5" : (!u && lf) ? "R6" : "R7";
    for (int r = 0; r < 16; r++) begin
      if (m == 0)      exp = a;
      else if (m == 1) exp = {16{l[r*8 +: 8]}};
      else             exp = {16{dc_of(a, l, u, lf)}};
      chk(req, row_data, exp);
      chk("R1", {row_valid, row_idx}, {1'b1, 4'(r)});
      chk("R8", done, r == 15);
      if (disturb && r == 2) begin
        above = ~a; left = ~l; mode = 2'd3; avail_up = ~u; avail_left = ~lf;   // R11
      end
      if (disturb && r == 6) start = 1'b1;   // R9
      if (disturb && r == 7) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8", {row_valid, done}, 2'b00);
  endtask

  function automatic logic [127:0] pat(input int k);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'($urandom_range(0, 255));
    if (k == 0) v = '0;
    if (k == 1) v = {16{8'hFF}};
    if (k == 2) for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(i * 17);
    return v;
  endfunction

  initial begin
    #1;
    chk("R1", {row_valid, done, plane_go}, 3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {row_valid, done, plane_go}, 3'b000);
    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 3; m++)
        for (int f = 0; f < 4; f++)
          run_block(2'(m), f[1], f[0], pat(k), pat(k + 1), (k + f) % 2 == 1);
    run_block(2'd2, 1'b1, 1'b1, {16{8'hFF}}, {16{8'hFF}}, 1'b0);   // R7 no wrap
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      mode = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", {plane_go, row_valid}, 2'b10);
      @(negedge clk);
      chk("R10", {plane_go, row_valid}, 2'b00);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule